// File: doc/BRIEF.md
# Prioritized Interrupt Distributor with Acknowledge

This block gathers level-sensitive interrupt lines from peripherals and steers each one to one of several CPU interfaces. Every source owns a small configuration word with an enable bit, an 8-bit priority and a target CPU index. An enabled source whose line is high becomes pending. For each CPU the block picks the most urgent pending source routed to it. The CPU's IRQ line is raised only when that source's priority beats the CPU's priority threshold.

Software works through a synchronous register port. It takes an interrupt by reading the acknowledge register of its CPU. That read returns the interrupt number and marks the interrupt active, which removes it from arbitration. Software finishes the interrupt by writing the same number to the end-of-interrupt register. If the line is still high at that point, the interrupt becomes pending again.

Top module: `prio_irq_distributor`

## Requirements
- R1: A source whose enable bit (bit 0 of its configuration word) is clear never becomes pending and never raises an IRQ line, whatever its input line does.
- R2: An enabled, inactive source whose line is high shows as pending (status bit 24 of its configuration word). Pending is level-following: if the line drops before acknowledge, the pending state clears.
- R3: Among the candidates of one CPU, the source with the numerically lowest priority (bits 15:8) wins. Equal priorities go to the lower interrupt number.
- R4: The target field (bits 23:16) routes a source to CPU interface of that index. A target value of NUM_CPU or more reaches no CPU.
- R5: A CPU's IRQ output is high exactly while its winner has a priority strictly below that CPU's 8-bit mask. The mask resets to 0, which blocks everything.
- R6: Reading a CPU's acknowledge register returns the winning interrupt number and makes that source active (status bit 25). An active source takes no part in arbitration.
- R7: When no interrupt qualifies for the CPU, an acknowledge read returns 1023 and changes no state.
- R8: Writing an interrupt number (bits 9:0) to a CPU's end-of-interrupt register clears that source's active state, but only if the source targets the same CPU. Other writes are ignored.
- R9: If the source line is still high and the source is enabled at end-of-interrupt, it becomes pending again and can raise the IRQ line.
- R10: After reset, every configuration word, status bit and mask reads 0, every IRQ line is low and the read data is 0.
- R11: Register map (word addresses). Address i (i < NUM_IRQ) is the configuration word of source i. For CPU c, the mask is at 0x80+4c, the acknowledge register at 0x80+4c+1 and the end-of-interrupt register at 0x80+4c+2. Read data appears on the clock edge that samples the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src_i | input | NUM_IRQ | Level interrupt lines, one per source |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| cpu_irq_o | output | NUM_CPU | Level IRQ line per CPU interface |

## Verification
The delicate coincidence is an acknowledge read on the same clock edge at which a more urgent source's line rises. The bench drives the new line in the same cycle as the acknowledge strobe. It expects the read to return the interrupt that was already winning, and expects the newcomer to come back from the next acknowledge. A second coincidence is end-of-interrupt while the line stays high: the bench expects the source to re-enter pending and raise the IRQ line again. Random traffic mixes these with configuration rewrites and mask changes. After every step, a bench model checks both IRQ lines and every acknowledge value.

// File: rtl/irqd_pkg.sv
// Shared widths, constants and the per-source configuration type
// of the interrupt distributor.
package irqd_pkg;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 8;
    localparam int PRIO_W      = 8;
    localparam int TGT_W       = 8;
    localparam int ID_W        = 10;
    localparam int SPURIOUS_ID = 1023;

    // Offsets inside one CPU's four-word window.
    localparam logic [1:0] SEL_MASK = 2'd0;
    localparam logic [1:0] SEL_ACK  = 2'd1;
    localparam logic [1:0] SEL_EOI  = 2'd2;

    typedef struct packed {
        logic              en;
        logic [PRIO_W-1:0] prio;
        logic [TGT_W-1:0]  tgt;
    } irq_cfg_t;

    // Extract the writable fields from a bus word.
    function automatic irq_cfg_t cfg_from_word(input logic [DATA_W-1:0] w);
        irq_cfg_t c;
        c.en   = w[0];
        c.prio = w[15:8];
        c.tgt  = w[23:16];
        return c;
    endfunction
endpackage

// File: rtl/irqd_src_cell.sv
// One interrupt source: holds its configuration word, samples its level
// line into a pending flag and tracks the active state between
// acknowledge and end-of-interrupt.
// Assumes ack_i and eoi_i are never high together (single register port).
module irqd_src_cell
    import irqd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     src_i,
    input  logic     cfg_we_i,
    input  irq_cfg_t cfg_wdata_i,
    input  logic     ack_i,
    input  logic     eoi_i,
    output irq_cfg_t cfg_o,
    output logic     pend_o,
    output logic     act_o
);
    irq_cfg_t cfg_q;
    logic     pend_q;
    logic     act_q;

    // Configuration word, written from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_q <= '0;
        else if (cfg_we_i) cfg_q <= cfg_wdata_i;
    end

    // Level-following pending flag, blocked while active.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= cfg_q.en & src_i & ~act_q;
    end

    // Active state: set by acknowledge, cleared by end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)     act_q <= 1'b0;
        else if (ack_i) act_q <= 1'b1;
        else if (eoi_i) act_q <= 1'b0;
    end

    assign cfg_o  = cfg_q;
    assign pend_o = pend_q;
    assign act_o  = act_q;

    AST_OFF_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.en |=> !pend_q); // R1
    AST_LEVEL_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.en && src_i && !act_q) |=> pend_q); // R2
    AST_ACK_TAKES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |-> (pend_q && !act_q)); // R6
    AST_EOI_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !ack_i) |=> !act_q); // R8
endmodule

// File: rtl/irqd_cpu_port.sv
// One CPU interface: holds the priority mask, arbitrates among the
// candidate sources routed to this CPU (lowest value wins, ties to the
// lower number) and qualifies the winner against the mask.
// Assumes cand_i already excludes disabled, active and foreign sources.
module irqd_cpu_port
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            mask_we_i,
    input  logic [PRIO_W-1:0]               mask_wdata_i,
    input  logic [NUM_IRQ-1:0]              cand_i,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio_i,
    output logic [PRIO_W-1:0]               mask_o,
    output logic [NUM_IRQ-1:0]              win_oh_o,
    output logic [ID_W-1:0]                 win_id_o,
    output logic                            qual_o
);
    logic [PRIO_W-1:0]  mask_q;
    logic               best_v;
    logic [PRIO_W-1:0]  best_p;
    logic [ID_W-1:0]    best_id;
    logic [NUM_IRQ-1:0] best_oh;

    // Priority threshold register for this CPU.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_we_i) mask_q <= mask_wdata_i;
    end

    // Linear scan: a later source replaces only on a strictly lower value.
    always_comb begin
        best_v  = 1'b0;
        best_p  = '1;
        best_id = '0;
        best_oh = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (cand_i[i] && (!best_v || prio_i[i] < best_p)) begin
                best_v     = 1'b1;
                best_p     = prio_i[i];
                best_id    = ID_W'(i);
                best_oh    = '0;
                best_oh[i] = 1'b1;
            end
        end
    end

    assign mask_o   = mask_q;
    assign win_oh_o = best_oh;
    assign win_id_o = best_id;
    assign qual_o   = best_v && (best_p < mask_q);

    AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(best_oh)); // R3
    AST_WIN_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        (best_oh & ~cand_i) == '0); // R3
    AST_ZERO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !qual_o); // R5
endmodule

// File: rtl/prio_irq_distributor.sv
// Interrupt distributor top: decodes the register port, instantiates one
// state cell per source and one arbitration port per CPU, forms the
// acknowledge and end-of-interrupt strobes and registers read data.
// Assumes NUM_IRQ <= 64 and NUM_CPU <= 16 (address map limits).
module prio_irq_distributor
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter int NUM_CPU = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_src_i,
    input  logic               bus_en_i,
    input  logic               bus_we_i,
    input  logic [7:0]         bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    output logic [NUM_CPU-1:0] cpu_irq_o
);
    localparam int IDX_W = 6;
    localparam int CPU_W = 4;

    logic [IDX_W-1:0] src_idx;
    logic [CPU_W-1:0] cpu_idx;
    logic [1:0]       cpu_sel;
    logic             cfg_hit;
    logic             cpu_hit;
    logic             ack_rd;
    logic             eoi_wr;
    logic             unused_wdata;

    irq_cfg_t                          cfg_all [NUM_IRQ];
    logic [NUM_IRQ-1:0]                pend_all;
    logic [NUM_IRQ-1:0]                act_all;
    logic [NUM_IRQ-1:0][PRIO_W-1:0]    prio_all;
    logic [NUM_IRQ-1:0]                ack_set;
    logic [NUM_IRQ-1:0]                eoi_clr;
    logic [NUM_CPU-1:0][NUM_IRQ-1:0]   cand;
    logic [NUM_CPU-1:0][NUM_IRQ-1:0]   win_oh;
    logic [NUM_CPU-1:0][ID_W-1:0]      win_id;
    logic [NUM_CPU-1:0][PRIO_W-1:0]    mask_all;
    logic [NUM_CPU-1:0]                qual;
    logic [NUM_CPU-1:0]                cpu_pick;
    logic [31:0]                       rd_next;
    logic                              sel_qual;

    assign src_idx      = bus_addr_i[5:0];
    assign cpu_idx      = bus_addr_i[5:2];
    assign cpu_sel      = bus_addr_i[1:0];
    assign cfg_hit      = bus_en_i && !bus_addr_i[7] && !bus_addr_i[6]
                          && (32'(src_idx) < NUM_IRQ);
    assign cpu_hit      = bus_en_i && bus_addr_i[7] && !bus_addr_i[6]
                          && (32'(cpu_idx) < NUM_CPU);
    assign ack_rd       = cpu_hit && !bus_we_i && (cpu_sel == SEL_ACK);
    assign eoi_wr       = cpu_hit &&  bus_we_i && (cpu_sel == SEL_EOI);
    assign unused_wdata = ^bus_wdata_i[31:24];

    // Decode which CPU window the current access addresses.
    always_comb begin
        for (int c = 0; c < NUM_CPU; c++) begin
            cpu_pick[c] = cpu_hit && (cpu_idx == CPU_W'(c));
        end
    end

    // Acknowledge strobe: the qualifying winner of the addressed CPU.
    always_comb begin
        ack_set = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (ack_rd && cpu_pick[c] && qual[c]) ack_set = ack_set | win_oh[c];
        end
    end

    genvar gi, gc;
    generate
        for (gi = 0; gi < NUM_IRQ; gi++) begin : g_src
            // End-of-interrupt applies only to a source routed to the writer.
            assign eoi_clr[gi] = eoi_wr
                && (bus_wdata_i[ID_W-1:0] == ID_W'(gi))
                && (cfg_all[gi].tgt == TGT_W'(cpu_idx));

            irq_cfg_t cell_cfg;
            irqd_src_cell u_cell (
                .clk         (clk),
                .rst_n       (rst_n),
                .src_i       (irq_src_i[gi]),
                .cfg_we_i    (cfg_hit && bus_we_i && (src_idx == IDX_W'(gi))),
                .cfg_wdata_i (cfg_from_word(bus_wdata_i)),
                .ack_i       (ack_set[gi]),
                .eoi_i       (eoi_clr[gi]),
                .cfg_o       (cell_cfg),
                .pend_o      (pend_all[gi]),
                .act_o       (act_all[gi])
            );
            assign cfg_all[gi]  = cell_cfg;
            assign prio_all[gi] = cell_cfg.prio;

            for (gc = 0; gc < NUM_CPU; gc++) begin : g_route
                assign cand[gc][gi] = pend_all[gi] && !act_all[gi] && cell_cfg.en
                                      && (cell_cfg.tgt == TGT_W'(gc));
            end
        end

        for (gc = 0; gc < NUM_CPU; gc++) begin : g_cpu
            irqd_cpu_port #(.NUM_IRQ(NUM_IRQ)) u_port (
                .clk          (clk),
                .rst_n        (rst_n),
                .mask_we_i    (cpu_pick[gc] && bus_we_i && (cpu_sel == SEL_MASK)),
                .mask_wdata_i (bus_wdata_i[PRIO_W-1:0]),
                .cand_i       (cand[gc]),
                .prio_i       (prio_all),
                .mask_o       (mask_all[gc]),
                .win_oh_o     (win_oh[gc]),
                .win_id_o     (win_id[gc]),
                .qual_o       (qual[gc])
            );
        end
    endgenerate

    assign cpu_irq_o = qual;

    // Read multiplexer for configuration words and CPU registers.
    always_comb begin
        rd_next  = '0;
        sel_qual = 1'b0;
        if (cfg_hit) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (src_idx == IDX_W'(i)) begin
                    rd_next = {6'd0, act_all[i], pend_all[i] & ~act_all[i],
                               cfg_all[i].tgt, cfg_all[i].prio, 7'd0, cfg_all[i].en};
                end
            end
        end else if (cpu_hit) begin
            for (int c = 0; c < NUM_CPU; c++) begin
                if (cpu_pick[c]) begin
                    sel_qual = qual[c];
                    if (cpu_sel == SEL_MASK) rd_next = 32'(mask_all[c]);
                    else if (cpu_sel == SEL_ACK)
                        rd_next = qual[c] ? 32'(win_id[c]) : 32'(SPURIOUS_ID);
                end
            end
        end
    end

    // Registered read data, updated on every read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                    bus_rdata_o <= '0;
        else if (bus_en_i && !bus_we_i) bus_rdata_o <= rd_next;
    end

    AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_set)); // R6
    AST_SPURIOUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !sel_qual) |=> (bus_rdata_o == 32'(SPURIOUS_ID))); // R7
    AST_NO_ACK_WHEN_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !sel_qual) |-> (ack_set == '0)); // R7
endmodule

// File: tb/prio_irq_distributor_bench.sv
module prio_irq_distributor_bench;
    localparam int NI = 16;
    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] src = '0;
    logic          ben = 1'b0, bwe = 1'b0;
    logic [7:0]    badr = '0;
    logic [31:0]   bwd = '0;
    logic [31:0]   brd;
    logic [NC-1:0] irq;

    int nvec = 0, nfail = 0;
    bit m_en [NI];
    int m_prio [NI];
    int m_tgt [NI];
    bit m_act [NI];
    int m_mask [NC];

    always #10 clk = ~clk;

    prio_irq_distributor #(.NUM_IRQ(NI), .NUM_CPU(NC)) u_prio_irq_distributor (
        .clk(clk), .rst_n(rst_n), .irq_src_i(src), .bus_en_i(ben), .bus_we_i(bwe),
        .bus_addr_i(badr), .bus_wdata_i(bwd), .bus_rdata_o(brd), .cpu_irq_o(irq));

    task automatic check(input int act, input int exp, input string req);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic int exp_win(input int c, output bit q);
        int b = -1;
        for (int i = 0; i < NI; i++)
            if (m_en[i] && src[i] && !m_act[i] && m_tgt[i] == c && (b < 0 || m_prio[i] < m_prio[b]))
                b = i;
        q = (b >= 0) && (m_prio[b] < m_mask[c]);
        return b;
    endfunction

    task automatic settle(); repeat (2) @(negedge clk); endtask

    task automatic bus_wr(input int a, input int d);
        @(negedge clk); ben = 1; bwe = 1; badr = 8'(a); bwd = 32'(d);
        @(negedge clk); ben = 0; bwe = 0;
    endtask

    task automatic bus_rd(input int a, output int d);
        @(negedge clk); ben = 1; bwe = 0; badr = 8'(a);
        @(negedge clk); ben = 0; d = int'(brd);
    endtask

    task automatic cfg(input int i, input bit en, input int pr, input int tg);
        bus_wr(i, (tg << 16) | (pr << 8) | int'(en));
        m_en[i] = en; m_prio[i] = pr; m_tgt[i] = tg;
        settle();
    endtask

    task automatic set_mask(input int c, input int m);
        bus_wr(8'h80 + 4*c, m); m_mask[c] = m; settle();
    endtask

    task automatic do_ack(input int c, input string req);
        bit q; int id, d;
        id = exp_win(c, q);
        bus_rd(8'h80 + 4*c + 1, d);
        check(d, q ? id : 1023, req);
        if (q) m_act[id] = 1;
        settle();
    endtask

    task automatic do_eoi(input int c, input int id);
        bus_wr(8'h80 + 4*c + 2, id);
        if (id < NI && m_act[id] && m_tgt[id] == c) m_act[id] = 0;
        settle();
    endtask

    task automatic chk_irqs(input string req);
        bit q; int b;
        for (int c = 0; c < NC; c++) begin
            b = exp_win(c, q);
            check(int'(irq[c]), int'(q), req);
        end
    endtask

    task automatic chk_status(input int i, input string req);
        int d, e;
        bus_rd(i, d);
        e = (int'(m_act[i]) << 25) | (int'(m_en[i] && src[i] && !m_act[i]) << 24)
            | (m_tgt[i] << 16) | (m_prio[i] << 8) | int'(m_en[i]);
        check(d, e, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        int d;
        void'($urandom(32'd4242));
        for (int i = 0; i < NI; i++) begin m_en[i] = 0; m_prio[i] = 0; m_tgt[i] = 0; m_act[i] = 0; end
        for (int c = 0; c < NC; c++) m_mask[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        check(int'(irq), 0, "R10 irq lines");
        check(int'(brd), 0, "R10 rdata");
        chk_status(5, "R10 config word");
        bus_rd(8'h80, d); check(d, 0, "R10 mask");
        // R5 zero mask blocks even an enabled pending source
        src[4] = 1; cfg(4, 1, 8'h10, 0);
        chk_irqs("R5 zero mask");
        do_ack(0, "R7 spurious under zero mask");
        set_mask(0, 8'hFF); set_mask(1, 8'hFF);
        chk_irqs("R5 open mask"); check(int'(irq[0]), 1, "R5 irq0 up");
        chk_status(4, "R2 pending status");
        // R1 disabled source ignored
        src[6] = 1; cfg(6, 0, 8'h00, 0);
        chk_status(6, "R1 disabled not pending");
        do_ack(0, "R1 disabled loses to enabled");
        chk_status(4, "R6 active bit");
        chk_irqs("R6 active leaves arbitration");
        do_ack(0, "R7 spurious with only active");
        // R8 eoi from wrong CPU ignored, R9 re-pend with line high
        do_eoi(1, 4);
        chk_status(4, "R8 foreign eoi ignored");
        do_eoi(0, 4);
        chk_status(4, "R9 re-pend after eoi");
        check(int'(irq[0]), 1, "R9 irq returns");
        // R2 level drop clears pending
        src[4] = 0; settle();
        chk_status(4, "R2 drop clears pending");
        chk_irqs("R2 irq follows level");
        // R3 tie to lower number
        src[3] = 1; src[5] = 1; cfg(3, 1, 8'h40, 0); cfg(5, 1, 8'h40, 0);
        do_ack(0, "R3 tie lower id");
        do_ack(0, "R3 second of tie");
        do_eoi(0, 3); do_eoi(0, 5);
        // R5 boundary: priority equal to mask is blocked
        set_mask(0, 8'h40); chk_irqs("R5 prio equals mask");
        check(int'(irq[0]), 0, "R5 equal blocked");
        set_mask(0, 8'h41); check(int'(irq[0]), 1, "R5 below mask passes");
        // R4 routing to CPU 1 and to nowhere
        cfg(3, 1, 8'h20, 1); cfg(5, 1, 8'h10, 7);
        chk_irqs("R4 routing"); check(int'(irq[1]), 1, "R4 cpu1 sees 3");
        do_ack(1, "R4 ack on cpu1");
        do_eoi(1, 3);
        // Coincidence: source rises in the acknowledge cycle
        cfg(5, 0, 0, 0); cfg(3, 0, 0, 0); set_mask(0, 8'hFF);
        src[2] = 1; cfg(2, 1, 8'h40, 0); cfg(1, 1, 8'h10, 0);
        begin
            bit q; int id;
            id = exp_win(0, q);
            @(negedge clk); ben = 1; bwe = 0; badr = 8'h81; src[1] = 1;
            @(negedge clk); ben = 0;
            check(int'(brd), id, "R6 ack sees old winner");
            if (q) m_act[id] = 1;
            settle();
        end
        do_ack(0, "R3 newcomer wins next");
        do_eoi(0, 1); do_eoi(0, 2);
        // Constrained random traffic
        for (int k = 0; k < 700; k++) begin
            int op = $urandom_range(0, 9);
            int i  = $urandom_range(0, NI-1);
            int c  = $urandom_range(0, NC-1);
            case (op)
                0, 1: begin src[i] = ~src[i]; settle(); end
                2: cfg(i, 1'($urandom_range(0, 3) != 0), $urandom_range(0, 3) * 8'h40,
                       $urandom_range(0, 2));
                3: set_mask(c, ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : 8'hFF);
                4, 5: do_ack(c, "R6 random ack");
                6, 7: do_eoi(c, ($urandom_range(0, 7) == 0) ? $urandom_range(0, 1023) : i);
                default: chk_status(i, "R11 random status");
            endcase
            chk_irqs("R5 random irq");
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule